// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt lines and presents them to a processor as two request outputs. One is a normal request and the other is a fast request. Each line has its own enable bit, a routing bit that picks the fast or the normal output, a 4-bit priority and a software force bit. A simple synchronous 32-bit register bus programs these settings. The same bus reads back the raw inputs, the two pending sets and two vector words.

The normal vector word names the pending normal source with the highest priority, subject to a priority threshold. Software services interrupts in a loop. It reads the normal vector, handles that source and clears the source's enable bit. It repeats until the vector reads 0xFFFF. Writing a source number to a dedicated register enables that one source, and a second register disables it. Neither needs a read-modify-write.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every enable, routing and force bit is 0 and every priority is 0. The threshold at byte address 0x04 reads 0x1F. Both vector words (0x40 normal, 0x44 fast) read 0xFFFF0000, and both request outputs are low.
- R2: A source is normal-pending when (input OR force) AND enable AND NOT routing. It is fast-pending when the same terms hold AND routing. Normal pending reads at 0x58 (sources 32–63) and 0x5C (sources 0–31). Fast pending reads at 0x60 and 0x64. Bit n of a word is source n modulo 32. A source is never in both sets.
- R3: A write to 0x08 sets only the enable bit of the source numbered by wdata[5:0]. A write to 0x0C clears only that bit. Whole enable words are at 0x10 (high) and 0x14 (low).
- R4: Routing words are at 0x18 (high) and 0x1C (low), and a 1 routes a source to the fast output. The fast output is high exactly when some source is fast-pending.
- R5: Priorities sit in eight words. The word for sources 8x..8x+7 is at 0x20+4*(7−x), and source 8x+k uses bits [4k+3:4k] of that word.
- R6: Bits [31:16] of 0x40 give the number of the eligible normal-pending source with the highest priority, and bits [15:0] give its priority. When priorities are equal, the higher source number wins.
- R7: When no normal source is eligible and pending, 0x40 reads 0xFFFF0000 and the normal output is low. Otherwise the normal output is high.
- R8: The threshold at 0x04 is 5 bits wide. At values 16 and above it blocks nothing. Below 16, only normal sources with a priority strictly greater than the threshold are eligible. The threshold does not change the pending words.
- R9: Force words at 0x50 (high) and 0x54 (low) assert sources as if their inputs were high, and they read back as written.
- R10: Bits [31:16] of 0x44 give the highest-numbered fast-pending source, or 0xFFFF when there is none, and bits [15:0] read 0.
- R11: Raw inputs read at 0x48 (high) and 0x4C (low), and writes to those addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_lvl | input | 64 | Level-sensitive interrupt inputs |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is a tie in priority between two pending normal sources whose priority words are programmed at inverted offsets. A close second is the exact point where the threshold turns a source from blocked to eligible. The stimulus places two sources in the topmost priority group with the same priority. It also places a lower-priority source in group 0. It then checks that the higher number wins, disables the winner by number to follow the service loop, and steps the threshold one value either side of the survivor's priority. Rerouting that survivor to the fast output then shows the hand-over between the two vector words.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
    localparam int SRC_N  = 64;
    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(SRC_N);

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_LEVEL  = 8'h04;
    localparam logic [7:0] A_ENNUM  = 8'h08;
    localparam logic [7:0] A_DISNUM = 8'h0C;
    localparam logic [7:0] A_ENH    = 8'h10;
    localparam logic [7:0] A_ENL    = 8'h14;
    localparam logic [7:0] A_TYPH   = 8'h18;
    localparam logic [7:0] A_TYPL   = 8'h1C;
    localparam logic [7:0] A_NVEC   = 8'h40;
    localparam logic [7:0] A_FVEC   = 8'h44;
    localparam logic [7:0] A_SRCH   = 8'h48;
    localparam logic [7:0] A_SRCL   = 8'h4C;
    localparam logic [7:0] A_FRCH   = 8'h50;
    localparam logic [7:0] A_FRCL   = 8'h54;
    localparam logic [7:0] A_NPH    = 8'h58;
    localparam logic [7:0] A_NPL    = 8'h5C;
    localparam logic [7:0] A_FPH    = 8'h60;
    localparam logic [7:0] A_FPL    = 8'h64;

    localparam logic [15:0] NO_VEC  = 16'hFFFF;
endpackage

// File: rtl/irq_vector_regs.sv
module irq_vector_regs
    import irq_vector_pkg::*;
#(
    parameter int PRIO_W = 4,
    parameter int LVL_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    output logic [SRC_N-1:0]         en_q,
    output logic [SRC_N-1:0]         typ_q,
    output logic [SRC_N-1:0]         frc_q,
    output logic [SRC_N*PRIO_W-1:0]  prio_q,
    output logic [LVL_W-1:0]         lvl_q
);
    localparam int NGRP = SRC_N * PRIO_W / WORD_W;

    typedef struct packed {
        logic [SRC_N-1:0]        en;
        logic [SRC_N-1:0]        typ;
        logic [SRC_N-1:0]        frc;
        logic [SRC_N*PRIO_W-1:0] prio;
        logic [LVL_W-1:0]        lvl;
    } cfg_t;

    cfg_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_LEVEL:  st_d.lvl = wr_data[LVL_W-1:0];
                A_ENNUM:  st_d.en[wr_data[IDX_W-1:0]] = 1'b1;
                A_DISNUM: st_d.en[wr_data[IDX_W-1:0]] = 1'b0;
                A_ENH:    st_d.en[SRC_N-1:WORD_W]  = wr_data;
                A_ENL:    st_d.en[WORD_W-1:0]      = wr_data;
                A_TYPH:   st_d.typ[SRC_N-1:WORD_W] = wr_data;
                A_TYPL:   st_d.typ[WORD_W-1:0]     = wr_data;
                A_FRCH:   st_d.frc[SRC_N-1:WORD_W] = wr_data;
                A_FRCL:   st_d.frc[WORD_W-1:0]     = wr_data;
                default: begin
                    // priority words: group x lives at 0x20 + 4*(7-x)
                    if (wr_addr[7:5] == 3'b001 && wr_addr[1:0] == 2'b00) begin
                        for (int g = 0; g < NGRP; g++) begin
                            if (wr_addr[4:2] == 3'(NGRP - 1 - g))
                                st_d.prio[g*WORD_W +: WORD_W] = wr_data;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lvl  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q   = st_q.en;
    assign typ_q  = st_q.typ;
    assign frc_q  = st_q.frc;
    assign prio_q = st_q.prio;
    assign lvl_q  = st_q.lvl;

    AST_ENNUM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ENNUM) |=> en_q[$past(wr_data[IDX_W-1:0])]); // R3
    AST_DISNUM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DISNUM) |=> !en_q[$past(wr_data[IDX_W-1:0])]); // R3
    AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == A_TYPH || wr_addr == A_TYPL)) |=> $stable(typ_q)); // R4
endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
    import irq_vector_pkg::*;
#(
    parameter int PRIO_W = 4,
    parameter int LVL_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SRC_N-1:0]         npend,
    input  logic [SRC_N-1:0]         fpend,
    input  logic [SRC_N*PRIO_W-1:0]  prio,
    input  logic [LVL_W-1:0]         lvl,
    output logic                     n_valid,
    output logic [IDX_W-1:0]         n_idx,
    output logic [PRIO_W-1:0]        n_prio,
    output logic                     f_valid,
    output logic [IDX_W-1:0]         f_idx
);
    logic [SRC_N-1:0] elig;

    // eligibility per source against the threshold
    for (genvar i = 0; i < SRC_N; i++) begin : g_elig
        assign elig[i] = npend[i] &&
            (lvl[LVL_W-1] || ({1'b0, prio[i*PRIO_W +: PRIO_W]} > lvl));
    end

    always_comb begin
        n_valid = 1'b0;
        n_idx   = '0;
        n_prio  = '0;
        f_valid = 1'b0;
        f_idx   = '0;
        for (int i = 0; i < SRC_N; i++) begin
            // ascending scan with >= lets the higher number win a tie
            if (elig[i] && (!n_valid || prio[i*PRIO_W +: PRIO_W] >= n_prio)) begin
                n_valid = 1'b1;
                n_idx   = IDX_W'(i);
                n_prio  = prio[i*PRIO_W +: PRIO_W];
            end
            if (fpend[i]) begin
                f_valid = 1'b1;
                f_idx   = IDX_W'(i);
            end
        end
    end

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        n_valid |-> npend[n_idx]); // R6
    AST_WINNER_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (n_valid && !lvl[LVL_W-1]) |-> ({1'b0, n_prio} > lvl)); // R8
    AST_FAST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid |-> fpend[f_idx]); // R10
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int PRIO_W = 4,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [63:0]       src_lvl,
    output logic              irq_norm,
    output logic              irq_fast
);
    localparam int NGRP = SRC_N * PRIO_W / WORD_W;

    logic [SRC_N-1:0]        en_q, typ_q, frc_q;
    logic [SRC_N*PRIO_W-1:0] prio_q;
    logic [LVL_W-1:0]        lvl_q;
    logic [SRC_N-1:0]        active, npend, fpend;
    logic                    n_valid, f_valid;
    logic [IDX_W-1:0]        n_idx, f_idx;
    logic [PRIO_W-1:0]       n_prio;

    irq_vector_regs #(.PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .en_q(en_q), .typ_q(typ_q), .frc_q(frc_q),
        .prio_q(prio_q), .lvl_q(lvl_q)
    );

    assign active = (src_lvl | frc_q) & en_q;
    assign npend  = active & ~typ_q;
    assign fpend  = active & typ_q;

    irq_vector_arb #(.PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .npend(npend), .fpend(fpend),
        .prio(prio_q), .lvl(lvl_q), .n_valid(n_valid), .n_idx(n_idx),
        .n_prio(n_prio), .f_valid(f_valid), .f_idx(f_idx)
    );

    assign irq_norm = n_valid;
    assign irq_fast = f_valid;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_LEVEL: bus_rdata = WORD_W'(lvl_q);
            A_ENH:   bus_rdata = en_q[SRC_N-1:WORD_W];
            A_ENL:   bus_rdata = en_q[WORD_W-1:0];
            A_TYPH:  bus_rdata = typ_q[SRC_N-1:WORD_W];
            A_TYPL:  bus_rdata = typ_q[WORD_W-1:0];
            A_NVEC:  bus_rdata = n_valid ? {16'(n_idx), 16'(n_prio)} : {NO_VEC, 16'h0};
            A_FVEC:  bus_rdata = f_valid ? {16'(f_idx), 16'h0} : {NO_VEC, 16'h0};
            A_SRCH:  bus_rdata = src_lvl[SRC_N-1:WORD_W];
            A_SRCL:  bus_rdata = src_lvl[WORD_W-1:0];
            A_FRCH:  bus_rdata = frc_q[SRC_N-1:WORD_W];
            A_FRCL:  bus_rdata = frc_q[WORD_W-1:0];
            A_NPH:   bus_rdata = npend[SRC_N-1:WORD_W];
            A_NPL:   bus_rdata = npend[WORD_W-1:0];
            A_FPH:   bus_rdata = fpend[SRC_N-1:WORD_W];
            A_FPL:   bus_rdata = fpend[WORD_W-1:0];
            default: begin
                if (bus_addr[7:5] == 3'b001 && bus_addr[1:0] == 2'b00) begin
                    for (int g = 0; g < NGRP; g++) begin
                        if (bus_addr[4:2] == 3'(NGRP - 1 - g))
                            bus_rdata = prio_q[g*WORD_W +: WORD_W];
                    end
                end
            end
        endcase
    end

    AST_SETS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (npend & fpend) == '0); // R2
    AST_NO_NORM_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (npend == '0) |-> !irq_norm); // R7
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_lvl = '0;
    logic        irq_norm, irq_fast;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_pin;
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    // monitor: pops expected items and compares with what the design shows
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_pin ? {30'h0, irq_norm, irq_fast} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_pin = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic pins(input logic n, input logic f, input string tag);
        exp_t it;
        @(posedge clk); #1;
        it.is_pin = 1'b1; it.exp = {30'h0, n, f}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, 32'h1F, "R1 level");
        rd(8'h10, 32'h0, "R1 enable high");
        rd(8'h14, 32'h0, "R1 enable low");
        rd(8'h18, 32'h0, "R1 route high");
        rd(8'h1C, 32'h0, "R1 route low");
        rd(8'h40, 32'hFFFF0000, "R1 normal vector");
        rd(8'h44, 32'hFFFF0000, "R1 fast vector");
        pins(1'b0, 1'b0, "R1 outputs");

        // R3 set/clear by number touches a single bit
        wr(8'h08, 32'd5);
        rd(8'h14, 32'h20, "R3 enable 5");
        wr(8'h08, 32'd40);
        rd(8'h10, 32'h100, "R3 enable 40");
        wr(8'h0C, 32'd5);
        rd(8'h14, 32'h0, "R3 disable 5");
        rd(8'h10, 32'h100, "R3 other bit kept");
        wr(8'h0C, 32'd40);

        // R5 inverted priority word layout
        wr(8'h3C, 32'h0000_0030);
        wr(8'h20, 32'h5000_0000);
        rd(8'h3C, 32'h30, "R5 group0 word");
        rd(8'h20, 32'h5000_0000, "R5 group7 word");

        // R6 highest priority wins
        src_lvl[1] = 1'b1;
        wr(8'h08, 32'd1);
        rd(8'h5C, 32'h2, "R2 normal pending low");
        rd(8'h40, 32'h0001_0003, "R6 single source");
        pins(1'b1, 1'b0, "R7 normal out high");
        src_lvl[63] = 1'b1;
        wr(8'h08, 32'd63);
        rd(8'h58, 32'h8000_0000, "R2 normal pending high");
        rd(8'h40, 32'h003F_0005, "R6 higher priority");

        // R6 tie: higher number wins, then service loop by disabling
        wr(8'h20, 32'h5500_0000);
        src_lvl[62] = 1'b1;
        wr(8'h08, 32'd62);
        rd(8'h40, 32'h003F_0005, "R6 tie higher number");
        wr(8'h0C, 32'd63);
        rd(8'h40, 32'h003E_0005, "R6 next after ack");

        // R8 threshold
        wr(8'h04, 32'd5);
        rd(8'h40, 32'hFFFF0000, "R8 all blocked");
        pins(1'b0, 1'b0, "R7 normal out low when blocked");
        rd(8'h5C, 32'h2, "R8 pending unaffected");
        wr(8'h04, 32'd4);
        rd(8'h40, 32'h003E_0005, "R8 just above level");
        wr(8'h04, 32'h1F);

        // R4 routing to fast output
        wr(8'h18, 32'h4000_0000);
        rd(8'h18, 32'h4000_0000, "R4 route readback");
        rd(8'h40, 32'h0001_0003, "R4 routed source leaves normal");
        rd(8'h60, 32'h4000_0000, "R2 fast pending high");
        rd(8'h58, 32'h0, "R2 not in both sets");
        rd(8'h44, 32'h003E_0000, "R10 fast vector");
        pins(1'b1, 1'b1, "R4 both outputs");

        // R9 force
        src_lvl = '0;
        pins(1'b0, 1'b0, "R7 R4 inputs dropped");
        rd(8'h40, 32'hFFFF0000, "R7 empty vector");
        rd(8'h44, 32'hFFFF0000, "R10 empty fast vector");
        wr(8'h54, 32'h400);
        rd(8'h54, 32'h400, "R9 force readback");
        rd(8'h5C, 32'h0, "R9 forced but disabled");
        wr(8'h08, 32'd10);
        rd(8'h5C, 32'h400, "R9 forced pending");
        rd(8'h40, 32'h000A_0000, "R9 forced vector");

        // R11 raw inputs read-only
        src_lvl = 64'h1234_5678_9ABC_DEF0;
        rd(8'h48, 32'h1234_5678, "R11 raw high");
        rd(8'h4C, 32'h9ABC_DEF0, "R11 raw low");
        wr(8'h4C, 32'h0);
        rd(8'h4C, 32'h9ABC_DEF0, "R11 write ignored");

        // R10 highest-numbered fast source
        src_lvl = 64'h30;
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h64, 32'h430, "R2 fast pending low");
        rd(8'h44, 32'h000A_0000, "R10 highest number");
        rd(8'h40, 32'hFFFF0000, "R7 no normal left");
        pins(1'b0, 1'b1, "R4 fast only");
        wr(8'h54, 32'h0);
        rd(8'h44, 32'h0005_0000, "R10 after force removed");

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule